// File: doc/BRIEF.md
# Speculative Separable Switch Allocator

This block decides, once per clock, which virtual channel at each input port of an input-queued virtual-channel router may cross the crossbar, and to which output port. Every virtual channel brings an output-port request. Each request is marked speculative or non-speculative. A head flit that bids for the switch in the same cycle as its own virtual-channel allocation is speculative. Body and tail flits, which reuse the virtual channel their head already holds, are non-speculative. For each virtual channel the block also receives a flag that says whether that channel's virtual-channel allocation succeeded in the current cycle.

Two identical separable allocators work side by side, one on the non-speculative requests and one on the speculative ones. Each allocator has two stages of round-robin arbiters. The first stage picks one virtual channel per input port. The second stage picks one input port per output port. A merge stage then builds the result. A non-speculative grant always holds its output. A speculative grant is kept only if three things are true: its output is free of non-speculative grants, its input port holds no non-speculative grant, and its virtual-channel allocation succeeded. A speculative grant that is discarded leaves its output idle for that cycle, and the flit bids again later.

Grants depend on the inputs of the same cycle and on arbiter pointers that are stored in registers. All pins are plain control signals that are sampled every cycle. There is no valid/ready handshake and no back-pressure, because a request is simply held until it is granted.

Top module: `spec_switch_alloc`

## Requirements
- R1: After reset, every round-robin pointer gives priority to the lowest index. With no requests, `vc_gnt` and `xbar_vld` are all zero.
- R2: Each input port receives at most one grant per cycle, so `vc_gnt[i*V +: V]` is one-hot or zero.
- R3: Each output port carries at most one grant. `xbar_vld[o]` is high exactly when some virtual channel is granted to output `o`, and `xbar_sel[o*PW +: PW]` then holds that channel's input port index. The number of set bits in `vc_gnt` equals the number of set bits in `xbar_vld`.
- R4: When an output has both a non-speculative winner and a speculative winner, the non-speculative winner receives the output and the speculative one is dropped.
- R5: A speculative winner at an input port that already holds a non-speculative grant, to any output, is dropped.
- R6: A speculative winner whose `va_ok` bit is low is dropped, and its output stays idle (`xbar_vld[o]` = 0) in that cycle, unless a non-speculative grant holds that output.
- R7: Each arbiter moves its pointer to one past its winner only when that winner's grant survives the merge. Otherwise the pointer is kept, so a dropped winner keeps its priority.
- R8: Grants appear in the same cycle as the requests. A virtual channel with `req_valid` low, or with a requested port value of P or more, is never granted.
- R9: Virtual channel `v` of input port `i` uses flat index `k = i*V + v`. Its requested output port is the unsigned field `req_port[k*PW +: PW]`, where PW = max(1, ceil(log2 P)).

Grants are plain per-cycle outputs with no handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of all arbiter pointers |
| req_valid | input | P*V | Request present on virtual channel k |
| req_spec | input | P*V | 1 = speculative head-flit request, 0 = non-speculative |
| req_port | input | P*V*PW | Requested output port of each virtual channel, PW bits per channel |
| va_ok | input | P*V | Virtual-channel allocation for channel k succeeded this cycle |
| vc_gnt | output | P*V | Switch grant per virtual channel |
| xbar_vld | output | P | Output port o is driven this cycle |
| xbar_sel | output | P*PW | Input port index that feeds output o |

## Verification
The directed patterns are ordered so that the pointers are known at each step. The first two cycles put repeated non-speculative requests on one input, which shows pointer rotation. Next comes a clash at one output between a non-speculative and a speculative request, which separates output priority (R4) from input masking (R5). A speculative pair is then sent whose winner fails virtual-channel allocation and is resent once the allocation succeeds. This shows that a dropped winner keeps its priority and that the wasted output stays idle. A cycle with four disjoint grants tests the select encoding. After that, several thousand random cycles mix speculative flags, allocation failures and port clashes, and every cycle is compared against a behavioural model. This exposes errors in pointer updates and in the merge conditions that the directed cases do not reach.

// File: rtl/spec_sa_pkg.sv
package spec_sa_pkg;

  // Index width for n items, never below one bit.
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/spec_sa_rr_arb.sv
module spec_sa_rr_arb #(
  parameter int N = 4,
  localparam int IW = spec_sa_pkg::idx_w(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          adv,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] idx,
  output logic          any
);

  logic [IW-1:0] ptr;

  // Search starts at ptr and wraps; the first requester wins.
  always_comb begin
    int j;
    gnt = '0;
    idx = '0;
    any = 1'b0;
    for (int off = 0; off < N; off++) begin
      j = (int'(ptr) + off) % N;
      if (!any && req[j]) begin
        any    = 1'b1;
        gnt[j] = 1'b1;
        idx    = IW'(j);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      ptr <= '0;
    else if (adv && any)
      ptr <= (int'(idx) == N - 1) ? '0 : idx + 1'b1;
  end

  p_arb_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  p_arb_gnt_in_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0);
  p_arb_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(adv && any) |=> $stable(ptr));

endmodule

// File: rtl/spec_sa_sep_alloc.sv
module spec_sa_sep_alloc #(
  parameter int P = 4,
  parameter int V = 3,
  localparam int PW = spec_sa_pkg::idx_w(P),
  localparam int NV = P * V
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NV-1:0]   req,
  input  logic [NV*PW-1:0] port,
  input  logic [P-1:0]    keep,
  output logic [NV-1:0]   vc_gnt,
  output logic [P-1:0]    out_vld,
  output logic [P*PW-1:0] out_sel
);

  localparam int VW = spec_sa_pkg::idx_w(V);

  logic [NV-1:0]   m_req;
  logic [NV-1:0]   s1_gnt;
  logic [P*VW-1:0] in_vc;
  logic [P-1:0]    in_any;
  logic [P-1:0]    s1_adv;
  logic [P-1:0]    in_won;
  logic [PW-1:0]   in_port [P];
  logic [P-1:0]    s2_req [P];
  logic [P-1:0]    s2_gnt [P];

  // Requests naming a port that does not exist never enter arbitration.
  always_comb begin
    for (int k = 0; k < NV; k++)
      m_req[k] = req[k] && (int'(port[k*PW +: PW]) < P);
  end

  // Stage one: one V:1 arbiter per input port.
  for (genvar gi = 0; gi < P; gi++) begin : g_in
    spec_sa_rr_arb #(.N(V)) u_s1 (
      .clk (clk),
      .rst_n (rst_n),
      .req (m_req[gi*V +: V]),
      .adv (s1_adv[gi]),
      .gnt (s1_gnt[gi*V +: V]),
      .idx (in_vc[gi*VW +: VW]),
      .any (in_any[gi])
    );
  end

  always_comb begin
    for (int i = 0; i < P; i++)
      in_port[i] = port[(i*V + int'(in_vc[i*VW +: VW]))*PW +: PW];
    for (int o = 0; o < P; o++)
      for (int i = 0; i < P; i++)
        s2_req[o][i] = in_any[i] && (int'(in_port[i]) == o);
  end

  // Stage two: one P:1 arbiter per output port.
  for (genvar go = 0; go < P; go++) begin : g_out
    spec_sa_rr_arb #(.N(P)) u_s2 (
      .clk (clk),
      .rst_n (rst_n),
      .req (s2_req[go]),
      .adv (keep[go]),
      .gnt (s2_gnt[go]),
      .idx (out_sel[go*PW +: PW]),
      .any (out_vld[go])
    );
  end

  always_comb begin
    for (int i = 0; i < P; i++) begin
      in_won[i] = 1'b0;
      s1_adv[i] = 1'b0;
      for (int o = 0; o < P; o++) begin
        in_won[i] = in_won[i] | s2_gnt[o][i];
        s1_adv[i] = s1_adv[i] | (keep[o] & s2_gnt[o][i]);
      end
    end
    for (int k = 0; k < NV; k++)
      vc_gnt[k] = s1_gnt[k] && in_won[k / V];
  end

  p_keep_needs_vld_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (keep & ~out_vld) == '0);
  p_stage_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(vc_gnt) == $countones(out_vld));

endmodule

// File: rtl/spec_switch_alloc.sv
module spec_switch_alloc #(
  parameter int P = 4,
  parameter int V = 3,
  localparam int PW = spec_sa_pkg::idx_w(P),
  localparam int NV = P * V
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NV-1:0]    req_valid,
  input  logic [NV-1:0]    req_spec,
  input  logic [NV*PW-1:0] req_port,
  input  logic [NV-1:0]    va_ok,
  output logic [NV-1:0]    vc_gnt,
  output logic [P-1:0]     xbar_vld,
  output logic [P*PW-1:0]  xbar_sel
);

  logic [NV-1:0]   ns_req, sp_req;
  logic [NV-1:0]   ns_gnt, sp_gnt, sp_ok;
  logic [P-1:0]    ns_vld, sp_vld, sp_keep;
  logic [P*PW-1:0] ns_sel, sp_sel;
  logic [P-1:0]    ns_busy;

  assign ns_req = req_valid & ~req_spec;
  assign sp_req = req_valid & req_spec;

  spec_sa_sep_alloc #(.P(P), .V(V)) u_ns (
    .clk (clk), .rst_n (rst_n),
    .req (ns_req), .port (req_port), .keep (ns_vld),
    .vc_gnt (ns_gnt), .out_vld (ns_vld), .out_sel (ns_sel)
  );

  spec_sa_sep_alloc #(.P(P), .V(V)) u_sp (
    .clk (clk), .rst_n (rst_n),
    .req (sp_req), .port (req_port), .keep (sp_keep),
    .vc_gnt (sp_gnt), .out_vld (sp_vld), .out_sel (sp_sel)
  );

  // Merge: speculative winners survive only on idle outputs and inputs,
  // and only if their VC allocation succeeded.
  always_comb begin
    for (int i = 0; i < P; i++)
      ns_busy[i] = |ns_gnt[i*V +: V];
    sp_keep = '0;
    for (int k = 0; k < NV; k++) begin
      sp_ok[k] = sp_gnt[k] && va_ok[k] && !ns_busy[k / V]
               && !ns_vld[req_port[k*PW +: PW]];
      if (sp_ok[k])
        sp_keep[req_port[k*PW +: PW]] = 1'b1;
    end
    vc_gnt = ns_gnt | sp_ok;
    for (int o = 0; o < P; o++) begin
      xbar_vld[o] = ns_vld[o] | sp_keep[o];
      xbar_sel[o*PW +: PW] = ns_vld[o] ? ns_sel[o*PW +: PW] : sp_sel[o*PW +: PW];
    end
  end

  p_gnt_needs_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (vc_gnt & ~req_valid) == '0);
  p_spec_needs_va_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (vc_gnt & req_spec & ~va_ok) == '0);
  p_gnt_vs_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(vc_gnt) == $countones(xbar_vld));

  for (genvar gi = 0; gi < P; gi++) begin : g_chk
    p_one_per_input_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(vc_gnt[gi*V +: V]));
  end

endmodule

// File: tb/spec_switch_alloc_tb_top.sv
`timescale 1ns/1ps
module spec_switch_alloc_tb_top;

  localparam int P  = 4;
  localparam int V  = 3;
  localparam int PW = spec_sa_pkg::idx_w(P);
  localparam int NV = P * V;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NV-1:0]    req_valid = '0;
  logic [NV-1:0]    req_spec = '0;
  logic [NV*PW-1:0] req_port = '0;
  logic [NV-1:0]    va_ok = '0;
  logic [NV-1:0]    vc_gnt;
  logic [P-1:0]     xbar_vld;
  logic [P*PW-1:0]  xbar_sel;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int ns_p1[P], ns_p2[P], sp_p1[P], sp_p2[P];
  int nx_ns_p1[P], nx_ns_p2[P], nx_sp_p1[P], nx_sp_p2[P];

  always #10 clk = ~clk;

  spec_switch_alloc #(.P(P), .V(V)) dut_i (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid), .req_spec (req_spec),
    .req_port (req_port), .va_ok (va_ok),
    .vc_gnt (vc_gnt), .xbar_vld (xbar_vld), .xbar_sel (xbar_sel)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_stim();
    req_valid = '0; req_spec = '0; req_port = '0; va_ok = '0;
  endtask

  task automatic set_req(input int k, input int prt, input bit spec, input bit ok);
    req_valid[k] = 1'b1;
    req_spec[k]  = spec;
    req_port[k*PW +: PW] = PW'(prt);
    va_ok[k] = ok;
  endtask

  function automatic int pr(input int k);
    return int'(req_port[k*PW +: PW]);
  endfunction

  // Behavioural reference for the current cycle; stores next pointers.
  task automatic model_check(input string tag);
    int w1[2][P];
    int w2[2][P];
    bit busy[P];
    logic [NV-1:0] eg;
    logic [P-1:0] ev;
    logic [P*PW-1:0] es;
    for (int a = 0; a < 2; a++) begin
      for (int i = 0; i < P; i++) begin
        w1[a][i] = -1;
        for (int off = 0; off < V; off++) begin
          int v, k;
          v = ((a == 1 ? sp_p1[i] : ns_p1[i]) + off) % V;
          k = i * V + v;
          if (w1[a][i] < 0 && req_valid[k] && (req_spec[k] == (a == 1)) && pr(k) < P)
            w1[a][i] = v;
        end
      end
      for (int o = 0; o < P; o++) begin
        w2[a][o] = -1;
        for (int off = 0; off < P; off++) begin
          int i;
          i = ((a == 1 ? sp_p2[o] : ns_p2[o]) + off) % P;
          if (w2[a][o] < 0 && w1[a][i] >= 0 && pr(i * V + w1[a][i]) == o)
            w2[a][o] = i;
        end
      end
    end
    for (int i = 0; i < P; i++) begin
      busy[i] = 1'b0;
      for (int o = 0; o < P; o++) if (w2[0][o] == i) busy[i] = 1'b1;
    end
    eg = '0; ev = '0; es = '0;
    nx_ns_p1 = ns_p1; nx_ns_p2 = ns_p2; nx_sp_p1 = sp_p1; nx_sp_p2 = sp_p2;
    for (int o = 0; o < P; o++) begin
      if (w2[0][o] >= 0) begin
        int i;
        i = w2[0][o];
        ev[o] = 1'b1; es[o*PW +: PW] = PW'(i); eg[i*V + w1[0][i]] = 1'b1;
        nx_ns_p2[o] = (i + 1) % P;
        nx_ns_p1[i] = (w1[0][i] + 1) % V;
      end else if (w2[1][o] >= 0) begin
        int i;
        i = w2[1][o];
        if (!busy[i] && va_ok[i*V + w1[1][i]]) begin
          ev[o] = 1'b1; es[o*PW +: PW] = PW'(i); eg[i*V + w1[1][i]] = 1'b1;
          nx_sp_p2[o] = (i + 1) % P;
          nx_sp_p1[i] = (w1[1][i] + 1) % V;
        end
      end
    end
    chk({tag, " model vc_gnt R2 R4 R5 R6 R7"}, 64'(vc_gnt), 64'(eg));
    chk({tag, " model xbar_vld R3"}, 64'(xbar_vld), 64'(ev));
    for (int o = 0; o < P; o++)
      if (ev[o]) chk({tag, " model xbar_sel R9"}, 64'(xbar_sel[o*PW +: PW]), 64'(es[o*PW +: PW]));
  endtask

  task automatic end_cycle();
    @(posedge clk);
    #1;
    ns_p1 = nx_ns_p1; ns_p2 = nx_ns_p2; sp_p1 = nx_sp_p1; sp_p2 = nx_sp_p2;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < P; i++) begin
      ns_p1[i] = 0; ns_p2[i] = 0; sp_p1[i] = 0; sp_p2[i] = 0;
    end
    repeat (3) @(posedge clk);
    #2;
    chk("R1 reset vc_gnt", 64'(vc_gnt), 64'd0);
    chk("R1 reset xbar_vld", 64'(xbar_vld), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // T1: input 0, three VCs, all to port 0: VC0 first (R1).
    @(negedge clk); clear_stim();
    for (int v = 0; v < 3; v++) set_req(v, 0, 1'b0, 1'b1);
    #2;
    chk("R1 lowest index wins", 64'(vc_gnt), 64'h001);
    chk("R8 same-cycle select", 64'(xbar_sel[0 +: PW]), 64'd0);
    model_check("T1"); end_cycle();

    // T2: same requests: pointer rotated to VC1 (R7).
    @(negedge clk); #2;
    chk("R7 rotate after grant", 64'(vc_gnt), 64'h002);
    model_check("T2"); end_cycle();

    // T3: port 1 clash, non-spec input 1 vs spec input 2 (R4).
    @(negedge clk); clear_stim();
    set_req(3, 1, 1'b0, 1'b1);
    set_req(6, 1, 1'b1, 1'b1);
    #2;
    chk("R4 nonspec wins output", 64'(vc_gnt), 64'h008);
    chk("R4 select input 1", 64'(xbar_sel[1*PW +: PW]), 64'd1);
    model_check("T3"); end_cycle();

    // T4: spec winner fails VC allocation: output idle (R6), pointer kept (R7).
    @(negedge clk); clear_stim();
    set_req(6, 3, 1'b1, 1'b0);
    set_req(7, 3, 1'b1, 1'b1);
    #2;
    chk("R6 failed spec dropped", 64'(vc_gnt), 64'd0);
    chk("R6 output idle", 64'(xbar_vld), 64'd0);
    model_check("T4"); end_cycle();

    // T5: same VC retried with success: VC0 of input 2 still first (R7).
    @(negedge clk); va_ok[6] = 1'b1; #2;
    chk("R7 dropped winner keeps priority", 64'(vc_gnt), 64'h040);
    chk("R3 select input 2 on port 3", 64'(xbar_sel[3*PW +: PW]), 64'd2);
    model_check("T5"); end_cycle();

    // T6: input 1 non-spec to port 0, spec VC2 of input 1 to port 2 (R5).
    @(negedge clk); clear_stim();
    set_req(3, 0, 1'b0, 1'b1);
    set_req(5, 2, 1'b1, 1'b1);
    #2;
    chk("R5 spec masked on busy input", 64'(vc_gnt), 64'h008);
    chk("R5 port 2 idle", 64'(xbar_vld), 64'h1);
    model_check("T6"); end_cycle();

    // T7: four disjoint grants, mixed kinds (R3, R9).
    @(negedge clk); clear_stim();
    set_req(0, 3, 1'b0, 1'b1);
    set_req(4, 2, 1'b0, 1'b1);
    set_req(9, 1, 1'b0, 1'b1);
    set_req(8, 0, 1'b1, 1'b1);
    #2;
    chk("R3 four grants", 64'(vc_gnt), 64'h311);
    chk("R3 all outputs valid", 64'(xbar_vld), 64'hF);
    chk("R9 select encoding", 64'(xbar_sel), 64'(8'b00_01_11_10));
    model_check("T7"); end_cycle();

    // T8: no valid requests, only stale spec flags and ports (R8).
    @(negedge clk); clear_stim();
    req_spec = '1; va_ok = '1; req_port = '1;
    #2;
    chk("R8 invalid ignored", 64'(vc_gnt), 64'd0);
    model_check("T8"); end_cycle();

    // Random phase against the reference model.
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk); clear_stim();
      for (int k = 0; k < NV; k++)
        if (($urandom % 2) == 0)
          set_req(k, int'($urandom % P), ($urandom % 3) == 0, ($urandom % 4) != 0);
      #2;
      model_check("RND");
      end_cycle();
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule